// File: doc/BRIEF.md
# Break-Before-Make Power Path Switchover Sequencer

This block sits between a channel selector and the gate drivers of several input power paths feeding one common output rail. Its job is to make sure that only one path conducts at any time, and to move the rail from one path to another. A switchover happens when the requested channel changes or when the block is disabled. There is no fixed dead time. Each switchover instead waits for two latched confirmations from analog comparators, which the block sees as digital flags:

- The leaving channel must show that its gate is really off.
- The arriving channel must be granted a reverse-blocking permit. The permit means the rail has fallen below that channel's input, so closing the path cannot drive current back into the source.

The request is a small code: zero means no channel, and a value k from 1 to NCH names channel k. Channel k is driven by bit k-1 of the gate command vector. The sequencer reports which channel is connected, and it emits a one-cycle pulse each time it opens a conducting path. If the request keeps changing while a disconnect is in progress, the disconnect still runs to the end. After that the sequencer follows whatever request is current when the arriving channel's permit is found.

Top module: `bbm_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all gate commands are low, the connected code is 0 and the disconnect pulse is low.
- R2: In every cycle at most one bit of the gate command vector is high.
- R3: From the idle state, with enable high and request code k (1..NCH) whose permit latch is set, bit k-1 of the gate commands rises at the next clock edge, and the connected code becomes k in the same cycle.
- R4: A channel's permit latch is set by its reverse-blocking flag being high in any cycle. It is cleared on the edge where that channel's gate command falls, so a later reconnect needs a fresh flag.
- R5: While a channel is connected, enable going low or a request code that differs from the connected code drops every gate command at the next edge. The connected code reads 0 from that edge, and the disconnect pulse is high for exactly that one cycle.
- R6: After a disconnect, no gate command rises until the leaving channel's gate-off flag has been seen high in a cycle where its command was already low. The gate-off latch then sets at the next edge. The sequencer returns to idle one edge later, and a connect may follow at the edge after that.
- R7: A channel's gate-off flag is ignored while its gate command is high. Its gate-off latch is cleared on the edge where that command rises.
- R8: While idle, the channel that connects is chosen by the request code present in the cycle of connection, not by any earlier request.
- R9: A request code of 0, or enable held low, keeps all gate commands low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | High allows a channel to connect; low disconnects |
| req_ch | input | CW | Requested channel code, 0 = none, k = channel k |
| gate_off | input | NCH | Per-channel flag: gate is within its off threshold |
| rev_ok | input | NCH | Per-channel flag: rail has drooped below that input |
| gate_on | output | NCH | Per-channel gate-on command, bit k-1 for channel k |
| conn_ch | output | CW | Code of the connected channel, 0 when none |
| disc_pulse | output | 1 | One-cycle pulse when a connected channel is turned off |

## Verification
Each result follows its cause at a fixed delay:

- A gate-on, the connected code or the disconnect pulse follows the causing request or enable change at the very next edge.
- A flag reaches its latch one edge after it is seen, so a connect that depends on a fresh permit appears two edges after the flag.
- A drain ends two edges after the gate-off flag, and the connect can come at the third.

The bench drives inputs at the falling edge. It advances a cycle-level reference model at the rising edge using those same inputs, and it compares all three outputs at the following falling edge. Every expected value therefore lines up with the edge that produced it.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ON    = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_e;

endpackage

// File: rtl/bbm_latch_bank.sv
module bbm_latch_bank #(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] gate_off,
    input  logic [NCH-1:0] rev_ok,
    input  logic [NCH-1:0] on_q,
    input  logic [NCH-1:0] on_d,
    output logic [NCH-1:0] goff_q,
    output logic [NCH-1:0] rev_q
);

    typedef struct packed {
        logic [NCH-1:0] goff;
        logic [NCH-1:0] rev;
    } lat_t;

    lat_t lat_d, lat_q;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_comb begin
            // gate-off: sampled only while commanded off, cleared on turn-on
            if (on_d[i] && !on_q[i])
                lat_d.goff[i] = 1'b0;
            else
                lat_d.goff[i] = lat_q.goff[i] | (gate_off[i] & ~on_q[i]);
            // permit: cleared on turn-off
            if (on_q[i] && !on_d[i])
                lat_d.rev[i] = 1'b0;
            else
                lat_d.rev[i] = lat_q.rev[i] | rev_ok[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            lat_q <= '0;
        else
            lat_q <= lat_d;
    end

    assign goff_q = lat_q.goff;
    assign rev_q  = lat_q.rev;

endmodule

// File: rtl/bbm_seq_fsm.sv
module bbm_seq_fsm
    import bbm_pkg::*;
#(
    parameter int NCH = 3,
    localparam int CW = $clog2(NCH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic [CW-1:0]  req_ch,
    input  logic [NCH-1:0] goff_q,
    input  logic [NCH-1:0] rev_q,
    output logic [NCH-1:0] on_q,
    output logic [NCH-1:0] on_d,
    output logic           disc_q,
    output logic [CW-1:0]  conn_q
);

    typedef struct packed {
        seq_state_e     st;
        logic [CW-1:0]  cur;
        logic [NCH-1:0] on;
        logic           disc;
    } fsm_t;

    fsm_t s_d, s_q;

    logic [NCH-1:0] req_oh;
    logic [NCH-1:0] cur_oh;

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        assign req_oh[i] = (req_ch == CW'(i + 1));
        assign cur_oh[i] = (s_q.cur == CW'(i + 1));
    end

    always_comb begin
        s_d      = s_q;
        s_d.disc = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (enable && |(req_oh & rev_q)) begin
                    s_d.on  = req_oh;
                    s_d.cur = req_ch;
                    s_d.st  = ST_ON;
                end
            end
            ST_ON: begin
                if (!enable || req_ch != s_q.cur) begin
                    s_d.on   = '0;
                    s_d.disc = 1'b1;
                    s_d.st   = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                s_d.on = '0;
                if (|(cur_oh & goff_q)) begin
                    s_d.cur = '0;
                    s_d.st  = ST_IDLE;
                end
            end
            default: begin
                s_d.on  = '0;
                s_d.cur = '0;
                s_d.st  = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '{st: ST_IDLE, cur: '0, on: '0, disc: 1'b0};
        else
            s_q <= s_d;
    end

    assign on_q   = s_q.on;
    assign on_d   = s_d.on;
    assign disc_q = s_q.disc;
    assign conn_q = (s_q.st == ST_ON) ? s_q.cur : '0;

endmodule

// File: rtl/bbm_sequencer.sv
module bbm_sequencer #(
    parameter int NCH = 3,
    localparam int CW = $clog2(NCH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic [CW-1:0]  req_ch,
    input  logic [NCH-1:0] gate_off,
    input  logic [NCH-1:0] rev_ok,
    output logic [NCH-1:0] gate_on,
    output logic [CW-1:0]  conn_ch,
    output logic           disc_pulse
);

    logic [NCH-1:0] goff_lat;
    logic [NCH-1:0] rev_lat;
    logic [NCH-1:0] on_next;

    bbm_seq_fsm #(.NCH(NCH)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .req_ch (req_ch),
        .goff_q (goff_lat),
        .rev_q  (rev_lat),
        .on_q   (gate_on),
        .on_d   (on_next),
        .disc_q (disc_pulse),
        .conn_q (conn_ch)
    );

    bbm_latch_bank #(.NCH(NCH)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_off (gate_off),
        .rev_ok   (rev_ok),
        .on_q     (gate_on),
        .on_d     (on_next),
        .goff_q   (goff_lat),
        .rev_q    (rev_lat)
    );

endmodule

// File: rtl/bbm_sequencer_chk.sv
module bbm_sequencer_chk #(
    parameter int NCH = 3,
    localparam int CW = $clog2(NCH + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           enable,
    input logic [NCH-1:0] gate_on,
    input logic [CW-1:0]  conn_ch,
    input logic           disc_pulse,
    input logic [NCH-1:0] goff_q,
    input logic [NCH-1:0] rev_q
);

    AST_ONE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_on)); // R2

    AST_DISC_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        disc_pulse |-> (gate_on == '0) && ($past(gate_on) != '0)); // R5

    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (gate_on == '0)); // R5

    AST_CONN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_ch != '0) |-> $countones(gate_on) == 1); // R3

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        AST_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_on[i]) |-> $past(rev_q[i])); // R4

        AST_BREAK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_on[i]) |-> ($past(gate_on) == '0)); // R6

        AST_GOFF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_on[i]) |=> !goff_q[i]); // R7
    end

endmodule

bind bbm_sequencer bbm_sequencer_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .gate_on    (gate_on),
    .conn_ch    (conn_ch),
    .disc_pulse (disc_pulse),
    .goff_q     (goff_lat),
    .rev_q      (rev_lat)
);

// File: tb/bbm_sequencer_test.sv
module bbm_sequencer_test;

    localparam int NCH = 3;
    localparam int CW  = $clog2(NCH + 1);

    logic           clk = 1'b0;
    logic           rst_n;
    logic           enable;
    logic [CW-1:0]  req_ch;
    logic [NCH-1:0] gate_off;
    logic [NCH-1:0] rev_ok;
    logic [NCH-1:0] gate_on;
    logic [CW-1:0]  conn_ch;
    logic           disc_pulse;

    int    n_chk  = 0;
    int    n_bad  = 0;
    string tag    = "R1";

    // reference model state (0 idle, 1 on, 2 drain)
    int             m_st;
    int             m_cur;
    logic [NCH-1:0] m_on;
    logic           m_disc;
    logic [NCH-1:0] m_goff;
    logic [NCH-1:0] m_rev;

    always #10 clk = ~clk;

    bbm_sequencer #(.NCH(NCH)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .req_ch     (req_ch),
        .gate_off   (gate_off),
        .rev_ok     (rev_ok),
        .gate_on    (gate_on),
        .conn_ch    (conn_ch),
        .disc_pulse (disc_pulse)
    );

    function automatic int exp_conn();
        return (m_st == 1) ? m_cur : 0;
    endfunction

    task automatic model_reset();
        m_st = 0; m_cur = 0; m_on = '0; m_disc = 1'b0; m_goff = '0; m_rev = '0;
    endtask

    task automatic model_step();
        int             st_d   = m_st;
        int             cur_d  = m_cur;
        logic [NCH-1:0] on_d   = m_on;
        logic           disc_d = 1'b0;
        int             r      = int'(req_ch);
        case (m_st)
            0: if (enable && r >= 1 && r <= NCH && m_rev[r-1]) begin
                   on_d = '0; on_d[r-1] = 1'b1; cur_d = r; st_d = 1;
               end
            1: if (!enable || r != m_cur) begin
                   on_d = '0; disc_d = 1'b1; st_d = 2;
               end
            default: begin
                on_d = '0;
                if (m_goff[m_cur-1]) begin st_d = 0; cur_d = 0; end
            end
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (on_d[i] && !m_on[i]) m_goff[i] = 1'b0;
            else m_goff[i] = m_goff[i] | (gate_off[i] & ~m_on[i]);
            if (m_on[i] && !on_d[i]) m_rev[i] = 1'b0;
            else m_rev[i] = m_rev[i] | rev_ok[i];
        end
        m_st = st_d; m_cur = cur_d; m_on = on_d; m_disc = disc_d;
    endtask

    task automatic check(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("gate_on", int'(gate_on), int'(m_on));
        check("conn_ch", int'(conn_ch), exp_conn());
        check("disc_pulse", int'(disc_pulse), int'(m_disc));
    endtask

    task automatic cyc(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            if (rst_n) model_step(); else model_reset();
            @(negedge clk);
            compare_all();
            gate_off = '0;
            rev_ok   = '0;
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd5113));
        rst_n = 1'b0; enable = 1'b0; req_ch = '0; gate_off = '0; rev_ok = '0;
        model_reset();
        tag = "R1";
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R9: request 0 with permits latched stays off
        tag = "R9";
        enable = 1'b1; req_ch = 2'd0; rev_ok = 3'b111;
        cyc(3);
        enable = 1'b0; req_ch = 2'd1;
        cyc(2);

        // R3: connect channel 1 (permit already latched)
        tag = "R3";
        enable = 1'b1;
        cyc(2);
        check("R3 conn after request", int'(conn_ch), 1);

        // R7: gate-off flag ignored while on
        tag = "R7";
        gate_off = 3'b001;
        cyc(2);

        // R5: switch to channel 2 -> disconnect pulse
        tag = "R5";
        req_ch = 2'd2;
        cyc(1);
        check("R5 pulse on disconnect", int'(disc_pulse), 1);
        cyc(1);
        check("R5 pulse one cycle", int'(disc_pulse), 0);

        // R6: drain holds until fresh gate-off of channel 1
        tag = "R6";
        cyc(4);
        check("R6 no make before break", int'(gate_on), 0);
        req_ch = 2'd3;          // R8: request changes during drain
        gate_off = 3'b001;
        cyc(1);
        tag = "R8";
        cyc(3);
        check("R8 latest request wins", int'(conn_ch), 3);

        // R4: after ch3 drops, reconnect needs a fresh permit
        tag = "R4";
        enable = 1'b0;
        cyc(1);
        gate_off = 3'b100;
        cyc(2);
        enable = 1'b1;
        cyc(4);
        check("R4 stale permit cleared", int'(gate_on), 0);
        rev_ok = 3'b100;
        cyc(3);
        check("R4 fresh permit connects", int'(conn_ch), 3);

        // R2: constrained random
        tag = "R2";
        for (int t = 0; t < 5000; t++) begin
            enable   = ($urandom % 16) != 0;
            if (($urandom % 8) == 0) req_ch = CW'($urandom % (NCH + 1));
            gate_off = NCH'($urandom) & NCH'($urandom);
            rev_ok   = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
            if (($urandom % 500) == 0) begin
                rst_n = 1'b0;
                cyc(1);
                rst_n = 1'b1;
            end
            cyc(1);
        end
        finish_run();
    end

endmodule